// File: doc/BRIEF.md
# Heap Region Double-Free Checker

This block watches a stream of 32-bit instrumentation words delivered with a valid strobe by an upstream trace decoder. Software places a word into the trace at each allocation and each release of a heap region. The top twelve bits of the word say which kind of event it is, and the low twenty bits name the region. The checker records whether each tracked region is currently held, and whether it has ever been held. It raises a registered one-cycle error with a code and the region ID whenever the event sequence shows misuse.

There are three kinds of misuse. A release of a region that was held and has since been released is a double free. A release of a region that has never been allocated gets its own code. An allocation of a region that is still held produces a reuse warning, and the region stays held. A synchronous clear input returns every tracked region to the never-allocated state. The number of tracked regions is a parameter. The region table is indexed by the low bits of the region ID, so IDs that agree in those bits share one entry.

Top module: `alloc_guard`

## Requirements
- R1: After reset, err_pulse is 0, err_code is 0, err_region is 0, and every region entry is in the never-allocated state.
- R2: A word with in_word[31:20] = 0xFFF is an allocation event and a word with in_word[31:20] = 0xFFE is a release event. The region ID is in_word[19:0]. The table entry is selected by the low log2(REGIONS) bits of the ID (bits [7:0] with the default 256 regions).
- R3: A release of an entry that was allocated and has since been released, with no allocation in between, reports err_code 2'b01 (double free). The entry stays released.
- R4: A release of an entry never allocated since reset or the last clear reports err_code 2'b10.
- R5: An allocation of an entry that is currently allocated reports err_code 2'b11. The entry stays allocated.
- R6: An allocation of a released or never-allocated entry, and a release of an allocated entry, report no error.
- R7: A valid word whose tag is neither 0xFFF nor 0xFFE reports no error and changes no entry.
- R8: An error appears as err_pulse high for exactly the one clock after the edge that samples the offending word. err_region carries the full 20-bit ID of that word. While err_pulse is low, err_code and err_region are 0.
- R9: While clear is high at a clock edge, every entry returns to never-allocated. A word presented at the same edge is ignored and reports no error.
- R10: Cycles with in_valid low report no error and change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all region entries |
| in_valid | input | 1 | Qualifies in_word |
| in_word | input | 32 | Instrumentation word: tag and region ID |
| err_pulse | output | 1 | One-cycle error strobe |
| err_code | output | 2 | 01 double free, 10 never allocated, 11 reallocation |
| err_region | output | 20 | Region ID of the offending word |

## Verification
The bench replays the short misuse sequence alloc 1, alloc 2, free 1, alloc 3, free 1 and expects a double-free code only on the last word. A checker that kept no per-region history would miss that report or flag an earlier word. It releases a region that was never allocated and expects code 10. A design without the separate ever-allocated bit would report a double free there instead.

The bench also tests the other corner cases. It uses two IDs that share a table entry, so a design that indexed by the wrong bits would miss the reallocation. It sends words with unknown tags, and a design that decoded the tag loosely would change state. It presents a word in the same cycle as clear, and a design that gave the word priority would leave an entry allocated. Long random streams with a bench model then check the code and region on every cycle.

// File: rtl/alloc_guard_pkg.sv
package alloc_guard_pkg;
   typedef enum logic [1:0] {
      FLT_NONE    = 2'b00,
      FLT_DOUBLE  = 2'b01,
      FLT_NEVER   = 2'b10,
      FLT_REALLOC = 2'b11
   } fault_e;
endpackage

// File: rtl/ag_classify.sv
module ag_classify #(
   parameter int          WORD_W    = 32,
   parameter int          TAG_W     = 12,
   parameter int          IDX_W     = 8,
   parameter logic [11:0] ALLOC_TAG = 12'hFFF,
   parameter logic [11:0] FREE_TAG  = 12'hFFE,
   localparam int         ID_W      = WORD_W - TAG_W
) (
   input  logic              valid,
   input  logic [WORD_W-1:0] word,
   output logic              is_alloc,
   output logic              is_free,
   output logic [IDX_W-1:0]  idx,
   output logic [ID_W-1:0]   id
);
   logic [TAG_W-1:0] tag;

   assign tag      = word[WORD_W-1 -: TAG_W];
   assign id       = word[ID_W-1:0];
   assign idx      = id[IDX_W-1:0];
   assign is_alloc = valid && (tag == ALLOC_TAG[TAG_W-1:0]);
   assign is_free  = valid && (tag == FREE_TAG[TAG_W-1:0]);
endmodule

// File: rtl/ag_region_table.sv
module ag_region_table #(
   parameter int REGIONS = 256,
   parameter int IDX_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [IDX_W-1:0] idx,
   input  logic             set_live,
   input  logic             drop_live,
   output logic             rd_live,
   output logic             rd_seen
);
   logic [REGIONS-1:0] live_q;
   logic [REGIONS-1:0] seen_q;

   for (genvar g = 0; g < REGIONS; g++) begin : g_entry
      logic sel;
      assign sel = (idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_q[g] <= 1'b0;
            seen_q[g] <= 1'b0;
         end else if (clear) begin
            live_q[g] <= 1'b0;
            seen_q[g] <= 1'b0;
         end else if (sel && set_live) begin
            live_q[g] <= 1'b1;
            seen_q[g] <= 1'b1;
         end else if (sel && drop_live) begin
            live_q[g] <= 1'b0;
         end
      end
   end

   assign rd_live = live_q[idx];
   assign rd_seen = seen_q[idx];
endmodule

// File: rtl/ag_report.sv
module ag_report
   import alloc_guard_pkg::*;
#(
   parameter int ID_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  fault_e          fault,
   input  logic [ID_W-1:0] id,
   output logic            err_pulse,
   output logic [1:0]      err_code,
   output logic [ID_W-1:0] err_region
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_pulse  <= 1'b0;
         err_code   <= 2'b00;
         err_region <= '0;
      end else begin
         err_pulse  <= (fault != FLT_NONE);
         err_code   <= fault;
         err_region <= (fault != FLT_NONE) ? id : '0;
      end
   end
endmodule

// File: rtl/alloc_guard.sv
module alloc_guard
   import alloc_guard_pkg::*;
#(
   parameter int          WORD_W    = 32,
   parameter int          TAG_W     = 12,
   parameter int          REGIONS   = 256,
   parameter logic [11:0] ALLOC_TAG = 12'hFFF,
   parameter logic [11:0] FREE_TAG  = 12'hFFE,
   localparam int         ID_W      = WORD_W - TAG_W,
   localparam int         IDX_W     = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              err_pulse,
   output logic [1:0]        err_code,
   output logic [ID_W-1:0]   err_region
);
   if (TAG_W > 12 || TAG_W < 1) begin : g_bad_tag
      $error("alloc_guard: TAG_W must be 1..12");
   end
   if (ALLOC_TAG == FREE_TAG) begin : g_bad_codes
      $error("alloc_guard: allocation and release tags must differ");
   end
   if (REGIONS < 2 || (REGIONS & (REGIONS - 1)) != 0) begin : g_bad_depth
      $error("alloc_guard: REGIONS must be a power of two of at least 2");
   end
   if (IDX_W > ID_W) begin : g_bad_idx
      $error("alloc_guard: region table wider than the region ID");
   end

   logic             is_alloc, is_free, rd_live, rd_seen;
   logic             set_live, drop_live;
   logic [IDX_W-1:0] idx;
   logic [ID_W-1:0]  id;
   fault_e           fault;

   ag_classify #(
      .WORD_W(WORD_W), .TAG_W(TAG_W), .IDX_W(IDX_W),
      .ALLOC_TAG(ALLOC_TAG), .FREE_TAG(FREE_TAG)
   ) u_classify (
      .valid(in_valid), .word(in_word), .is_alloc(is_alloc),
      .is_free(is_free), .idx(idx), .id(id)
   );

   ag_region_table #(.REGIONS(REGIONS), .IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .clear(clear), .idx(idx),
      .set_live(set_live), .drop_live(drop_live),
      .rd_live(rd_live), .rd_seen(rd_seen)
   );

   always_comb begin
      fault     = FLT_NONE;
      set_live  = 1'b0;
      drop_live = 1'b0;
      if (!clear) begin
         if (is_alloc) begin
            set_live = 1'b1;
            if (rd_live) fault = FLT_REALLOC;
         end else if (is_free) begin
            if (rd_live)      drop_live = 1'b1;
            else if (rd_seen) fault = FLT_DOUBLE;
            else              fault = FLT_NEVER;
         end
      end
   end

   ag_report #(.ID_W(ID_W)) u_report (
      .clk(clk), .rst_n(rst_n), .fault(fault), .id(id),
      .err_pulse(err_pulse), .err_code(err_code), .err_region(err_region)
   );
endmodule

// File: rtl/ag_guard_chk.sv
module ag_guard_chk #(
   parameter int          WORD_W    = 32,
   parameter int          TAG_W     = 12,
   parameter logic [11:0] ALLOC_TAG = 12'hFFF,
   parameter logic [11:0] FREE_TAG  = 12'hFFE,
   localparam int         ID_W      = WORD_W - TAG_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear,
   input logic              in_valid,
   input logic [WORD_W-1:0] in_word,
   input logic              err_pulse,
   input logic [1:0]        err_code,
   input logic [ID_W-1:0]   err_region
);
   logic [TAG_W-1:0] tag_w;
   assign tag_w = in_word[WORD_W-1 -: TAG_W];

   p_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> ($past(in_valid) && !$past(clear)));
   p_clear_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> !err_pulse);
   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !err_pulse |-> (err_code == 2'b00 && err_region == '0));
   p_region_echo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (err_region == $past(in_word[ID_W-1:0])));
   p_alloc_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pulse && $past(tag_w) == ALLOC_TAG[TAG_W-1:0]) |-> err_code == 2'b11);
   p_free_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pulse && $past(tag_w) == FREE_TAG[TAG_W-1:0])
         |-> (err_code == 2'b01 || err_code == 2'b10));
   p_other_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> ($past(tag_w) == ALLOC_TAG[TAG_W-1:0]
                  || $past(tag_w) == FREE_TAG[TAG_W-1:0]));
endmodule

bind alloc_guard ag_guard_chk #(
   .WORD_W(WORD_W), .TAG_W(TAG_W), .ALLOC_TAG(ALLOC_TAG), .FREE_TAG(FREE_TAG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
   .in_word(in_word), .err_pulse(err_pulse), .err_code(err_code),
   .err_region(err_region)
);

// File: tb/sim_alloc_guard.sv
`timescale 1ns/1ps
module sim_alloc_guard;
   localparam int NREG = 256;

   logic        clk = 1'b0;
   logic        rst_n, clear, in_valid;
   logic [31:0] in_word;
   logic        err_pulse;
   logic [1:0]  err_code;
   logic [19:0] err_region;

   always #2 clk = ~clk;

   alloc_guard u0 (
      .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
      .in_word(in_word), .err_pulse(err_pulse), .err_code(err_code),
      .err_region(err_region)
   );

   bit live_m [NREG];
   bit seen_m [NREG];
   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   function automatic logic [1:0] model(logic [31:0] w, logic v, logic c);
      int i;
      logic [1:0] r;
      r = 2'b00;
      if (c) begin
         for (int k = 0; k < NREG; k++) begin live_m[k] = 0; seen_m[k] = 0; end
         return 2'b00;
      end
      if (!v) return 2'b00;
      i = int'(w[7:0]);
      if (w[31:20] == 12'hFFF) begin
         if (live_m[i]) r = 2'b11;
         live_m[i] = 1; seen_m[i] = 1;
      end else if (w[31:20] == 12'hFFE) begin
         if (live_m[i]) live_m[i] = 0;
         else if (seen_m[i]) r = 2'b01;
         else r = 2'b10;
      end
      return r;
   endfunction

   task automatic step(logic [31:0] w, logic v, logic c, string req);
      logic [1:0]  ec;
      logic [19:0] er;
      @(negedge clk);
      in_word = w; in_valid = v; clear = c;
      ec = model(w, v, c);
      er = (ec != 2'b00) ? w[19:0] : 20'h0;
      @(posedge clk); #1;
      vectors++;
      if (err_pulse !== (ec != 2'b00) || err_code !== ec || err_region !== er) begin
         miscompares++;
         $display("FAIL %s: pulse=%0b code=%0d region=%h expected pulse=%0b code=%0d region=%h",
                  req, err_pulse, err_code, err_region, (ec != 2'b00), ec, er);
      end
   endtask

   function automatic logic [31:0] ev(logic [11:0] t, logic [19:0] id);
      return {t, id};
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int unsigned s;
      s = $urandom(32'd2024);
      rst_n = 1'b0; clear = 1'b0; in_valid = 1'b0; in_word = '0;
      repeat (3) @(posedge clk);
      #1;
      vectors++;
      if (err_pulse !== 1'b0 || err_code !== 2'b00 || err_region !== 20'h0) begin
         miscompares++;
         $display("FAIL R1: pulse=%0b code=%0d region=%h expected 0 0 0",
                  err_pulse, err_code, err_region);
      end
      @(negedge clk); rst_n = 1'b1;

      // R1 R4: every entry starts never-allocated
      step(ev(12'hFFE, 20'h00042), 1, 0, "R1");
      // R3 R6: the misuse sequence
      step(ev(12'hFFF, 20'h00001), 1, 0, "R6");
      step(ev(12'hFFF, 20'h00002), 1, 0, "R6");
      step(ev(12'hFFE, 20'h00001), 1, 0, "R6");
      step(ev(12'hFFF, 20'h00003), 1, 0, "R6");
      step(ev(12'hFFE, 20'h00001), 1, 0, "R3");
      step(ev(12'hFFE, 20'h00001), 0, 0, "R8");
      step(ev(12'hFFE, 20'h00001), 1, 0, "R3");
      // R4
      step(ev(12'hFFE, 20'h00005), 1, 0, "R4");
      // R5
      step(ev(12'hFFF, 20'h00002), 1, 0, "R5");
      step(ev(12'hFFE, 20'h00002), 1, 0, "R5");
      // R7: unknown tags leave entry 7 untouched
      step(ev(12'hABC, 20'h00007), 1, 0, "R7");
      step(ev(12'h7FF, 20'h00007), 1, 0, "R7");
      step(ev(12'hFFE, 20'h00007), 1, 0, "R7");
      // R10: invalid allocation has no effect
      step(ev(12'hFFF, 20'h00009), 0, 0, "R10");
      step(ev(12'hFFE, 20'h00009), 1, 0, "R10");
      // R2: aliasing through low 8 bits
      step(ev(12'hFFF, 20'h00100), 1, 0, "R2");
      step(ev(12'hFFF, 20'hABC00), 1, 0, "R2");
      // R9: clear with a word in the same cycle
      step(ev(12'hFFF, 20'h00011), 1, 0, "R9");
      step(ev(12'hFFF, 20'h00011), 1, 1, "R9");
      step(ev(12'hFFE, 20'h00011), 1, 0, "R9");
      step(ev(12'hFFE, 20'h00003), 1, 0, "R9");

      for (int n = 0; n < 4000; n++) begin
         logic [19:0] id;
         logic [11:0] t;
         int sel;
         id  = 20'(($urandom_range(0, 1) << 8) | $urandom_range(0, 15));
         id  = id | (20'($urandom_range(0, 3)) << 16);
         sel = $urandom_range(0, 9);
         t   = (sel < 4) ? 12'hFFF : (sel < 8) ? 12'hFFE : 12'h5A5;
         step(ev(t, id), sel != 9, ($urandom_range(0, 199) == 0), "R8");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule